// File: doc/BRIEF.md
# Dual Reloadable Interval Timer with Interrupt

This block holds two independent 8-bit interval timers behind a byte-wide register write port. Each timer counts base ticks upward from a programmed start value and signals an overflow after (256 - start) ticks. After an overflow, a running timer reloads its start value and continues, so it produces a steady periodic event. The base tick of each timer comes from its own clock prescaler, and the divide ratios are module parameters. The defaults give roughly 80.8 µs for timer A and 323.1 µs for timer B at a 50 MHz clock.

An overflow raises a per-timer flag unless that timer's mask bit is set in the control value. A single interrupt line is the OR of the flags. Software reads a status byte that carries the two flags together with the interrupt line. Software acknowledges events through the control register, either clearing every flag at once or clearing selected flags while it updates enables and masks.

Top module: `interval_timer_pair`

## Requirements
- R1: Reset (rstN low) clears the control value, both start values and both flags, and drives irqOut and statusOut low. With no further writes, no flag ever rises after reset.
- R2: Address 0x02 holds timer A's start value. With control bit 0 set, flag A (status bit 6) rises exactly (256 - start) * TICK_A_CLKS clocks after the write edge that started the timer. A start value of 0xFF gives one tick.
- R3: Address 0x03 holds timer B's start value. With control bit 1 set, flag B (status bit 5) rises exactly (256 - start) * TICK_B_CLKS clocks after the start. A start value of 0x00 gives 256 ticks.
- R4: A running timer reloads after each overflow and overflows again one full period later.
- R5: Writing a start value restarts that timer from the new value on the write edge, which discards any partly counted period.
- R6: A control write that changes a timer's enable bit restarts that timer, and a disabled timer never overflows. A control write that leaves the enable bit unchanged does not disturb the timer.
- R7: Control bit 6 masks timer A and control bit 5 masks timer B. A masked overflow leaves its flag unchanged.
- R8: A write to address 0x04 with bit 7 set clears both flags and changes nothing else. Enables, masks and running timers are kept.
- R9: A write to address 0x04 with bit 7 clear stores the byte as the new control value and clears each flag whose bit (6 for A, 5 for B) is set in the byte. The other flag is left alone.
- R10: irqOut is high exactly when at least one flag is set. statusOut is {irqOut, flagA, flagB, 5'b0}.
- R11: Writes to any address other than 0x02, 0x03 and 0x04 have no effect.
- R12: If an unmasked overflow and a clearing write hit the same flag on the same edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| wrAddr | input | 8 | Register address |
| wrData | input | 8 | Register write data |
| statusOut | output | 8 | Status byte: bit 7 interrupt, bit 6 flag A, bit 5 flag B |
| irqOut | output | 1 | Interrupt request, high while any flag is set |

## Verification
A wrong prescaler phase or wrong reload value shows up as a flag that rises one or more cycles early or late. The checks sample the cycle just before the expected edge and the cycle of the edge itself, so the error is caught within one timer period. Wrong decoding of the control byte shows up as a flag that survives an acknowledge or disappears too early, and the next status check after the write reveals it. A lost or spurious restart moves every later overflow in the run, so the check points that follow the restart expose it.

// File: rtl/itimer_pkg.sv
package itimer_pkg;
  localparam int NUM_TMR = 2;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 8;

  localparam logic [ADDR_W-1:0] REG_START_A = 8'h02;
  localparam logic [ADDR_W-1:0] REG_START_B = 8'h03;
  localparam logic [ADDR_W-1:0] REG_CTRL    = 8'h04;

  localparam int BIT_CLR_ALL = 7;

  // Flag/mask bit position of timer i (A=6, B=5)
  function automatic int flagPos(input int i);
    return 6 - i;
  endfunction

  // Strobes from control to datapath
  typedef struct packed {
    logic [NUM_TMR-1:0] load;     // new start value written
    logic [NUM_TMR-1:0] restart;  // enable bit toggled
    logic [DATA_W-1:0]  value;    // write data
  } tmrStrobe_t;
endpackage

// File: rtl/itimer_datapath.sv
module itimer_datapath
  import itimer_pkg::*;
#(
  parameter int TICK_A_CLKS = 4040,
  parameter int TICK_B_CLKS = 16155
) (
  input  logic               clk,
  input  logic               rstN,
  input  tmrStrobe_t         strobe,
  input  logic [NUM_TMR-1:0] run,
  output logic [NUM_TMR-1:0] ovf
);
  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    localparam int DIV = (i == 0) ? TICK_A_CLKS : TICK_B_CLKS;
    localparam int PW  = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] PRESC_LAST = PW'(DIV - 1);

    logic [DATA_W-1:0] startVal;
    logic [DATA_W-1:0] cnt;
    logic [PW-1:0]     presc;
    logic              tick;

    assign tick   = run[i] && (presc == PRESC_LAST);
    assign ovf[i] = tick && (cnt == {DATA_W{1'b1}});

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        startVal <= '0;
        cnt      <= '0;
        presc    <= '0;
      end else if (strobe.load[i]) begin
        startVal <= strobe.value;
        cnt      <= strobe.value;
        presc    <= '0;
      end else if (strobe.restart[i]) begin
        cnt      <= startVal;
        presc    <= '0;
      end else if (run[i]) begin
        if (tick) begin
          presc <= '0;
          cnt   <= ovf[i] ? startVal : cnt + 1'b1;
        end else begin
          presc <= presc + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/itimer_ctrl.sv
module itimer_ctrl
  import itimer_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_TMR-1:0] ovf,
  output tmrStrobe_t         strobe,
  output logic [NUM_TMR-1:0] run,
  output logic [DATA_W-1:0]  ctrlVal,
  output logic [NUM_TMR-1:0] flags
);
  logic wrCtrl, clearAll, ctrlUpd;

  assign wrCtrl   = wrEn && (wrAddr == REG_CTRL);
  assign clearAll = wrCtrl && wrData[BIT_CLR_ALL];
  assign ctrlUpd  = wrCtrl && !wrData[BIT_CLR_ALL];

  always_comb begin
    strobe.value   = wrData;
    strobe.load[0] = wrEn && (wrAddr == REG_START_A);
    strobe.load[1] = wrEn && (wrAddr == REG_START_B);
    for (int i = 0; i < NUM_TMR; i++)
      strobe.restart[i] = ctrlUpd && (wrData[i] != ctrlVal[i]);
  end

  assign run = ctrlVal[NUM_TMR-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        ctrlVal <= '0;
    else if (ctrlUpd) ctrlVal <= wrData;
  end

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_flag
    localparam int FP = flagPos(i);
    logic setF, clrF;
    assign setF = ovf[i] && !ctrlVal[FP];
    assign clrF = clearAll || (ctrlUpd && wrData[FP]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)     flags[i] <= 1'b0;
      else if (setF) flags[i] <= 1'b1;
      else if (clrF) flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/interval_timer_pair.sv
module interval_timer_pair
  import itimer_pkg::*;
#(
  parameter int TICK_A_CLKS = 4040,
  parameter int TICK_B_CLKS = 16155
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [7:0]  wrAddr,
  input  logic [7:0]  wrData,
  output logic [7:0]  statusOut,
  output logic        irqOut
);
  tmrStrobe_t         strobe;
  logic [NUM_TMR-1:0] run;
  logic [NUM_TMR-1:0] ovfPulse;
  logic [NUM_TMR-1:0] flags;
  logic [DATA_W-1:0]  ctrlVal;

  itimer_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .ovf     (ovfPulse),
    .strobe  (strobe),
    .run     (run),
    .ctrlVal (ctrlVal),
    .flags   (flags)
  );

  itimer_datapath #(
    .TICK_A_CLKS (TICK_A_CLKS),
    .TICK_B_CLKS (TICK_B_CLKS)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .run    (run),
    .ovf    (ovfPulse)
  );

  assign irqOut    = |flags;
  assign statusOut = {irqOut, flags[0], flags[1], 5'b0};
endmodule

// File: rtl/itimer_checker.sv
module itimer_checker (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [7:0] wrAddr,
  input logic [7:0] wrData,
  input logic [7:0] statusOut,
  input logic       irqOut,
  input logic [1:0] ovf,
  input logic [7:0] ctrlVal
);
  logic ctrlClr, foreignWr;
  assign ctrlClr   = wrEn && (wrAddr == 8'h04) && wrData[7];
  assign foreignWr = wrEn && (wrAddr != 8'h02) && (wrAddr != 8'h03) && (wrAddr != 8'h04);

  AST_FLAG_A_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusOut[6]) |-> $past(ovf[0] && !ctrlVal[6])); // R7
  AST_FLAG_B_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusOut[5]) |-> $past(ovf[1] && !ctrlVal[5])); // R7
  AST_STOPPED_QUIET_A: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlVal[0] |-> !ovf[0]); // R6
  AST_STOPPED_QUIET_B: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlVal[1] |-> !ovf[1]); // R6
  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlClr && ovf == 2'b00) |=> (statusOut[6:5] == 2'b00)); // R8
  AST_CTRL_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    ctrlClr |=> $stable(ctrlVal)); // R8
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(|ovf)); // R10
  AST_FOREIGN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (foreignWr && ovf == 2'b00) |=> ($stable(statusOut) && $stable(ctrlVal))); // R11
endmodule

bind interval_timer_pair itimer_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .wrAddr    (wrAddr),
  .wrData    (wrData),
  .statusOut (statusOut),
  .irqOut    (irqOut),
  .ovf       (ovfPulse),
  .ctrlVal   (ctrlVal)
);

// File: tb/interval_timer_pair_tb.sv
`timescale 1ns/1ps
module interval_timer_pair_tb;
  localparam int TA = 3;
  localparam int TB = 5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] statusOut;
  logic       irqOut;

  int errCnt = 0;
  int chkCnt = 0;
  bit done = 1'b0;

  interval_timer_pair #(.TICK_A_CLKS(TA), .TICK_B_CLKS(TB)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .statusOut(statusOut), .irqOut(irqOut)
  );

  always #10 clk = ~clk;

  // fields: addr, data, idle cycles after write, expected status, requirement
  localparam logic [39:0] VEC [0:11] = '{
    {8'h02, 8'hFC, 8'd0,  8'h00, 8'd5},   // R5 load while stopped
    {8'h04, 8'h01, 8'd11, 8'h00, 8'd2},   // R2 one cycle before overflow
    {8'h00, 8'hFF, 8'd0,  8'hC0, 8'd2},   // R2 R11 overflow edge
    {8'h04, 8'h81, 8'd10, 8'h00, 8'd8},   // R8 clear all
    {8'h07, 8'h00, 8'd0,  8'hC0, 8'd4},   // R4 reload period
    {8'h04, 8'h41, 8'd12, 8'h00, 8'd7},   // R7 R9 mask A + clear A
    {8'h04, 8'h01, 8'd9,  8'h00, 8'd6},   // R6 same enable, no restart
    {8'h09, 8'h00, 8'd0,  8'hC0, 8'd6},   // R6 phase kept
    {8'h03, 8'hFE, 8'd0,  8'hC0, 8'd3},   // R3 load B while stopped
    {8'h04, 8'h03, 8'd9,  8'hC0, 8'd3},   // R3 start B
    {8'h00, 8'h00, 8'd0,  8'hE0, 8'd3},   // R3 R10 both flags
    {8'h04, 8'h23, 8'd0,  8'hC0, 8'd9}    // R9 selective clear of B
  };

  task automatic chk(input logic [7:0] exp, input string req);
    chkCnt++;
    if (statusOut !== exp || irqOut !== exp[7]) begin
      errCnt++;
      $display("FAIL %s: status=%02h irq=%b expected status=%02h irq=%b",
               req, statusOut, irqOut, exp, exp[7]);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    idle(2);
    rstN = 1'b1;
    idle(1);
  endtask

  initial begin
    idle(2);
    rstN = 1'b1;
    idle(1);
    chk(8'h00, "R1 after reset");

    for (int k = 0; k < 12; k++) begin
      wr(VEC[k][39:32], VEC[k][31:24]);
      idle(int'(VEC[k][23:16]));
      chk(VEC[k][15:8], $sformatf("R%0d vector %0d", VEC[k][7:0], k));
    end

    // R1: reset mid-run clears everything and stops the timers
    doReset();
    chk(8'h00, "R1 reset mid-run");
    idle(30);
    chk(8'h00, "R1 stays quiet");

    // R5: rewrite start value during a period
    wr(8'h02, 8'hFE);
    wr(8'h04, 8'h01);
    idle(3);
    wr(8'h02, 8'hFD);
    idle(8);
    chk(8'h00, "R5 old period discarded");
    idle(1);
    chk(8'hC0, "R5 new period");

    // R6: disable, then re-enable restarts
    wr(8'h04, 8'h80);
    wr(8'h04, 8'h00);
    idle(40);
    chk(8'h00, "R6 disabled timer silent");
    wr(8'h04, 8'h01);
    idle(8);
    chk(8'h00, "R6 restart before edge");
    idle(1);
    chk(8'hC0, "R6 restart period");

    // R12: overflow and clear-all on the same edge
    wr(8'h04, 8'h81);
    chk(8'h00, "R8 clear");
    idle(7);
    wr(8'h04, 8'h81);
    chk(8'hC0, "R12 set beats clear");

    // R2 boundary: start 0xFF gives one tick
    wr(8'h04, 8'h80);
    wr(8'h02, 8'hFF);
    idle(2);
    chk(8'h00, "R2 FF before");
    idle(1);
    chk(8'hC0, "R2 FF one tick");

    // R3 boundary: start 0x00 after reset gives 256 ticks
    doReset();
    wr(8'h04, 8'h02);
    idle(256 * TB - 1);
    chk(8'h00, "R3 zero start before");
    idle(1);
    chk(8'hA0, "R3 zero start 256 ticks");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      errCnt++;
      chkCnt++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end
endmodule